// File: doc/BRIEF.md
# Drum Trigger Output Register

This block drives eight drum trigger lines from a processor write. Each write loads a byte into an eight-bit output register, and every bit of that byte drives one trigger line. A mode bit chooses how the register behaves. In hold mode a written value stays on the lines until the next write replaces it. In one-shot mode, a write that contains at least one 1 starts a single timer shared by all lines. When the timer runs out, all eight lines clear together. The length of the timer is a programmable count of clock cycles.

Trigger bytes arrive on a valid/ready port. The block never applies back-pressure: `trig_ready` is high at all times outside reset. A byte is taken on every clock edge where `trig_valid` is high. The mode bit and the width count are plain register-write pins, each with its own write enable. `busy` is high while the one-shot timer is running.

Top module: `drum_trig_out`

## Requirements
- R1: After reset, `trig_out` is 0, `busy` is 0, the mode is hold mode, the width register holds its reset value (8), and `trig_ready` is 1.
- R2: A write loads `trig_data` into `trig_out` in the cycle after the edge, bit for bit: data bit i drives trigger line i+1 (`trig_out[i]`). Every write is accepted, with no back-pressure.
- R3: In hold mode (`mode_val` = 0), `busy` stays 0 and `trig_out` keeps the last written value for as long as no further write arrives.
- R4: In one-shot mode (`mode_val` = 1), a write with any 1 bit sets `busy`. The written value stays on `trig_out` for exactly W cycles, where W is the width register. On the W-th edge after the write, all eight lines clear to 0 together and `busy` drops.
- R5: `width_we` loads `width_val` (16 bits) into the width register. A width of 0 acts as 1. A new width applies only to the next timer start; it does not change a timer that is already running.
- R6: In one-shot mode, a write of all zeros puts 0 on the lines and starts no timer. If a timer is running, that write cancels it.
- R7: In one-shot mode, a write with a 1 bit that arrives while `busy` is high replaces the output value and restarts the timer at the full width.
- R8: A switch to hold mode cancels a running timer and leaves the outputs as they are. A switch to one-shot mode does not start a timer by itself.
- R9: If a data write and a mode write happen on the same edge, the data write is handled in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger byte is present |
| trig_ready | output | 1 | Block accepts a byte (always 1 outside reset) |
| trig_data | input | 8 | Trigger byte; bit i drives line i+1 |
| mode_we | input | 1 | Write enable for the mode bit |
| mode_val | input | 1 | 0 = hold mode, 1 = one-shot mode |
| width_we | input | 1 | Write enable for the pulse width |
| width_val | input | 16 | Pulse width in clock cycles |
| trig_out | output | 8 | Drum trigger lines |
| busy | output | 1 | One-shot timer running |

## Verification
The bench sweeps all 256 bytes in hold mode. It sweeps widths 0 through 6 in one-shot mode and checks every cycle of each pulse. An off-by-one counter would clear the lines one cycle early or late. A design that treats width 0 literally would hold the lines forever or never raise them. The bench also targets a retrigger in the middle of a pulse, a zero write that cancels a pulse, and a width change while a pulse is running. Wrong handling here shows up as a pulse cut short by the old timer, or as lines that clear at the wrong time. A mode change to hold during a pulse, and mode and data written on the same edge, catch designs that clear held outputs or use the stale mode.

// File: rtl/drum_trig_pkg.sv
package drum_trig_pkg;
  typedef enum logic {
    MODE_HOLD    = 1'b0,
    MODE_ONESHOT = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/drum_trig_cfg.sv
module drum_trig_cfg
  import drum_trig_pkg::*;
#(
  parameter int WIDTH_BITS  = 16,
  parameter int RESET_WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_we,
  input  logic                  mode_val,
  input  logic                  width_we,
  input  logic [WIDTH_BITS-1:0] width_val,
  output trig_mode_e            mode_q,
  output trig_mode_e            mode_next,
  output logic [WIDTH_BITS-1:0] eff_width
);
  logic [WIDTH_BITS-1:0] width_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_HOLD;
      width_q <= WIDTH_BITS'(RESET_WIDTH);
    end else begin
      if (mode_we)  mode_q  <= trig_mode_e'(mode_val);
      if (width_we) width_q <= width_val;
    end
  end

  // The mode that applies on this edge: a mode write takes effect at once.
  assign mode_next = mode_we ? trig_mode_e'(mode_val) : mode_q;
  // A zero width is stretched to one cycle.
  assign eff_width = (width_q == '0) ? WIDTH_BITS'(1) : width_q;

  a_r5_width_load: assert property (@(posedge clk) disable iff (!rst_n)
    width_we |=> (eff_width == (($past(width_val) == '0) ? WIDTH_BITS'(1) : $past(width_val))));
  a_r5_width_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    eff_width != '0);
endmodule

// File: rtl/drum_trig_oneshot.sv
module drum_trig_oneshot #(
  parameter int WIDTH_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  cancel,
  input  logic [WIDTH_BITS-1:0] load_val,
  output logic                  busy,
  output logic                  expire
);
  logic [WIDTH_BITS-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= load_val;
    else if (cancel)        cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy   = (cnt_q != '0);
  assign expire = (cnt_q == WIDTH_BITS'(1)) && !start && !cancel;

  a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !cancel) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == $past(load_val)));
  a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !start) |=> !busy);
endmodule

// File: rtl/drum_trig_latch.sv
module drum_trig_latch #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LINES-1:0] din,
  input  logic             clear,
  output logic [LINES-1:0] lines
);
  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n)     lines[i] <= 1'b0;
        else if (load)  lines[i] <= din[i];
        else if (clear) lines[i] <= 1'b0;
      end
    end
  endgenerate

  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !load) |=> (lines == '0));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear) |=> $stable(lines));
endmodule

// File: rtl/drum_trig_out.sv
module drum_trig_out
  import drum_trig_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int WIDTH_BITS  = 16,
  parameter int RESET_WIDTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_valid,
  output logic                  trig_ready,
  input  logic [LINES-1:0]      trig_data,
  input  logic                  mode_we,
  input  logic                  mode_val,
  input  logic                  width_we,
  input  logic [WIDTH_BITS-1:0] width_val,
  output logic [LINES-1:0]      trig_out,
  output logic                  busy
);
  trig_mode_e            mode_q, mode_next;
  logic [WIDTH_BITS-1:0] eff_width;
  logic                  wr, any_one, oneshot_next, start, cancel, expire;

  drum_trig_cfg #(.WIDTH_BITS(WIDTH_BITS), .RESET_WIDTH(RESET_WIDTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
    .width_we(width_we), .width_val(width_val),
    .mode_q(mode_q), .mode_next(mode_next), .eff_width(eff_width));

  assign trig_ready   = rst_n;
  assign wr           = trig_valid && trig_ready;
  assign any_one      = |trig_data;
  assign oneshot_next = (mode_next == MODE_ONESHOT);
  assign start        = wr && any_one && oneshot_next;
  assign cancel       = !oneshot_next || (wr && !any_one);

  drum_trig_oneshot #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
    .load_val(eff_width), .busy(busy), .expire(expire));

  drum_trig_latch #(.LINES(LINES)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(wr), .din(trig_data),
    .clear(expire), .lines(trig_out));

  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && trig_out == $past(trig_data)));
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HOLD) |-> !busy);
  a_r4_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(mode_q) == MODE_ONESHOT && !$past(mode_we) && !$past(trig_valid))
      |-> (trig_out == '0));
  a_r8_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !mode_val && !trig_valid) |=> $stable(trig_out));
endmodule

// File: tb/drum_trig_out_test.sv
module drum_trig_out_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_valid = 1'b0;
  logic        trig_ready;
  logic [7:0]  trig_data = '0;
  logic        mode_we = 1'b0;
  logic        mode_val = 1'b0;
  logic        width_we = 1'b0;
  logic [15:0] width_val = '0;
  logic [7:0]  trig_out;
  logic        busy;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drum_trig_out uut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ready(trig_ready),
    .trig_data(trig_data), .mode_we(mode_we), .mode_val(mode_val),
    .width_we(width_we), .width_val(width_val), .trig_out(trig_out), .busy(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    trig_valid = 1'b1; trig_data = d;
    tick();
    trig_valid = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    mode_we = 1'b1; mode_val = m;
    tick();
    mode_we = 1'b0;
  endtask

  task automatic set_width(input logic [15:0] w);
    width_we = 1'b1; width_val = w;
    tick();
    width_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat;
    int eff;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 trig_out", trig_out, 0);
    chk("R1 busy", busy, 0);
    chk("R1 ready", trig_ready, 1);

    // R2 / R3: hold mode, every byte, bit mapping
    for (int v = 0; v < 256; v++) begin
      do_write(v[7:0]);
      chk("R2 load value", trig_out, v);
      chk("R3 busy low", busy, 0);
    end
    for (int i = 0; i < 8; i++) begin
      do_write(8'(1 << i));
      chk("R2 line mapping", trig_out[i], 1);
    end
    do_write(8'hA5);
    for (int i = 0; i < 20; i++) begin
      tick();
      chk("R3 hold value", trig_out, 8'hA5);
    end

    // R1 reset width of 8 applies to first pulse
    set_mode(1'b1);
    // R8: entering one-shot mode does not start a timer
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R8 no auto start", {busy, trig_out}, {1'b0, 8'hA5});
    end
    do_write(8'h3C);
    for (int j = 0; j < 8; j++) begin
      if (j > 0) tick();
      chk("R1 default width high", trig_out, 8'h3C);
    end
    tick();
    chk("R1 default width cleared", trig_out, 0);

    // R4 / R5 sweep of widths, 0 acting as 1
    for (int w = 0; w <= 6; w++) begin
      set_width(16'(w));
      eff = (w == 0) ? 1 : w;
      pat = 8'((8'h81 << (w % 8)) | 8'h01);
      do_write(pat);
      for (int j = 0; j < eff; j++) begin
        if (j > 0) tick();
        chk("R4 pulse high", {busy, trig_out}, {1'b1, pat});
      end
      tick();
      chk("R4 pulse cleared", {busy, trig_out}, 9'h0);
      tick();
      chk("R4 stays clear", trig_out, 0);
    end

    // R5 width change during a running pulse
    set_width(16'd5);
    do_write(8'h11);          // sample 0
    tick();                   // sample 1
    set_width(16'd2);         // sample 2
    tick(); tick();           // sample 4
    chk("R5 old width high", trig_out, 8'h11);
    tick();                   // sample 5
    chk("R5 old width cleared", {busy, trig_out}, 9'h0);
    do_write(8'h22);
    chk("R5 new width high", trig_out, 8'h22);
    tick(); chk("R5 new width high 2", trig_out, 8'h22);
    tick(); chk("R5 new width cleared", trig_out, 0);

    // R7 retrigger restarts full width
    set_width(16'd4);
    do_write(8'h0F);          // A0
    tick();                   // A1
    do_write(8'hF0);          // B0
    for (int j = 0; j < 4; j++) begin
      if (j > 0) tick();
      chk("R7 retrigger high", {busy, trig_out}, {1'b1, 8'hF0});
    end
    tick();
    chk("R7 retrigger cleared", {busy, trig_out}, 9'h0);

    // R6 zero write cancels and does not start
    set_width(16'd6);
    do_write(8'h44);
    tick();
    do_write(8'h00);
    chk("R6 zero cancel", {busy, trig_out}, 9'h0);
    do_write(8'h00);
    chk("R6 zero no start", busy, 0);

    // R8 switch to hold during a pulse keeps outputs
    do_write(8'h99);
    tick();
    set_mode(1'b0);
    chk("R8 cancel busy", busy, 0);
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R8 outputs kept", trig_out, 8'h99);
    end

    // R9 same-edge mode and data write uses new mode
    set_width(16'd3);
    mode_we = 1'b1; mode_val = 1'b1; trig_valid = 1'b1; trig_data = 8'h81;
    tick();
    mode_we = 1'b0; trig_valid = 1'b0;
    chk("R9 new mode pulse", {busy, trig_out}, {1'b1, 8'h81});
    tick(); tick();
    chk("R9 pulse last", trig_out, 8'h81);
    tick();
    chk("R9 pulse cleared", trig_out, 0);
    mode_we = 1'b1; mode_val = 1'b0; trig_valid = 1'b1; trig_data = 8'h42;
    tick();
    mode_we = 1'b0; trig_valid = 1'b0;
    chk("R9 new mode hold", {busy, trig_out}, {1'b0, 8'h42});
    for (int i = 0; i < 6; i++) tick();
    chk("R9 hold kept", trig_out, 8'h42);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule